// File: doc/BRIEF.md
# Interrupt Register Group

This block holds the interrupt state of a serial bus controller. Single-cycle event pulses from the controller core set bits in an eight-bit status register. Each bit stays set until software writes a 1 to it. A per-bit enable register masks the status. A single global enable bit gates all of them. The block reduces this state to one registered interrupt line for the system interrupt controller.

The same register window contains a soft-reset register. Writing one exact key word to it produces a one-cycle reset pulse for the rest of the peripheral. Any other value leaves that output low.

Software reaches the block through a simple 32-bit register port. The port has a write strobe, a read strobe and a byte offset. Read data appears one clock after the read strobe.

Top module: `intr_regs`

## Requirements
- R1: After synchronous reset, the status, enable and global-enable registers read as zero. While reset is held and after it, `irq_out`, `soft_rst_pulse` and `rdata` are 0 until a new stimulus arrives.
- R2: A 1 on `evt_pulse[i]` at a clock edge sets status bit i at offset 0x20. The bit stays set until it is cleared. The bit meanings are: 0 lost arbitration, 1 transmit error or transfer done, 2 transmit queue empty, 3 receive level reached, 4 bus idle, 5 selected as target, 6 deselected as target, 7 transmit queue half empty.
- R3: A write to offset 0x20 clears every status bit whose data bit is 1. Status bits whose data bit is 0 are unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: The enable register at offset 0x28 stores data bits 7:0. These bits read back at offset 0x28, and bits 31:8 read as zero.
- R6: The global enable at offset 0x1C is data bit 31 only. It reads back in bit 31, and all other bits read as zero.
- R7: `irq_out` is a register. One cycle after the state changes, it equals the global enable ANDed with the OR-reduction of (status AND enable).
- R8: A write of exactly 0x0000000A to offset 0x40 drives `soft_rst_pulse` high for the one cycle after the write edge.
- R9: A write of any other value to offset 0x40 leaves `soft_rst_pulse` low. Offset 0x40 reads as zero.
- R10: `rdata` is registered. It carries the addressed register in the cycle after `rd_en`, and is zero after a cycle without `rd_en`. Unmapped offsets read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte offset of the access |
| wdata | input | DATA_W (32) | Write data |
| evt_pulse | input | NUM_EVT (8) | Event pulses from the controller core |
| rdata | output | DATA_W (32) | Registered read data |
| irq_out | output | 1 | Combined interrupt request |
| soft_rst_pulse | output | 1 | One-cycle reset request to the peripheral |

## Verification
The bound checker watches several rules on every cycle:
- an event always leaves its status bit set, even under a coincident clear;
- a status bit falls only through a status write, and a clearing write removes exactly the requested bits that had no event;
- the interrupt line follows the gated, masked status one cycle later;
- the reset pulse appears after, and only after, a key write.

Other behaviour shows only in the bench's scenarios:
- the readback formats of the enable and global-enable registers;
- the zero reads of unmapped offsets;
- the harmlessness of writes to them;
- the exact cycle where the interrupt line rises and falls as the enables are toggled.

// File: rtl/intr_regs_pkg.sv
package intr_regs_pkg;

  localparam int GIE_OFS  = 'h1C;
  localparam int STAT_OFS = 'h20;
  localparam int IER_OFS  = 'h28;
  localparam int SRST_OFS = 'h40;

  localparam logic [31:0] SRST_KEY = 32'h0000_000A;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GIE,
    SEL_STAT,
    SEL_IER,
    SEL_SRST
  } reg_sel_e;

endpackage

// File: rtl/intr_status_bank.sv
module intr_status_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] status
);

  // one sticky cell per event; a new event outranks a clear
  for (genvar g = 0; g < N; g++) begin : g_cell
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)                          bit_q <= 1'b0;
      else if (evt[g])                  bit_q <= 1'b1;
      else if (clr_we && clr_bits[g])   bit_q <= 1'b0;
    end
    assign status[g] = bit_q;
  end

endmodule

// File: rtl/intr_key_decode.sv
module intr_key_decode #(
  parameter int          W   = 32,
  parameter logic [W-1:0] KEY = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit,
  input  logic [W-1:0] wdata,
  output logic         pulse
);

  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= hit && (wdata == KEY);
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/intr_irq_combine.sv
module intr_irq_combine #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] status,
  input  logic [N-1:0] ier,
  input  logic         gie,
  output logic         irq
);

  logic [N-1:0] pend;
  logic         irq_q;

  assign pend = status & ier;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= gie && (|pend);
  end

  assign irq = irq_q;

endmodule

// File: rtl/intr_regs.sv
module intr_regs
  import intr_regs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_out,
  output logic               soft_rst_pulse
);

  localparam int GIE_POS = DATA_W - 1;

  reg_sel_e            sel;
  logic                we_stat, we_ier, we_gie, we_srst;
  logic [NUM_EVT-1:0]  status_q;
  logic [NUM_EVT-1:0]  ier_q;
  logic                gie_q;
  logic [DATA_W-1:0]   rd_mux;
  logic [DATA_W-1:0]   rdata_q;

  always_comb begin
    if      (addr == ADDR_W'(GIE_OFS))  sel = SEL_GIE;
    else if (addr == ADDR_W'(STAT_OFS)) sel = SEL_STAT;
    else if (addr == ADDR_W'(IER_OFS))  sel = SEL_IER;
    else if (addr == ADDR_W'(SRST_OFS)) sel = SEL_SRST;
    else                                sel = SEL_NONE;
  end

  assign we_stat = wr_en && (sel == SEL_STAT);
  assign we_ier  = wr_en && (sel == SEL_IER);
  assign we_gie  = wr_en && (sel == SEL_GIE);
  assign we_srst = wr_en && (sel == SEL_SRST);

  intr_status_bank #(.N(NUM_EVT)) u_status (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_pulse),
    .clr_we   (we_stat),
    .clr_bits (wdata[NUM_EVT-1:0]),
    .status   (status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q <= '0;
      gie_q <= 1'b0;
    end else begin
      if (we_ier) ier_q <= wdata[NUM_EVT-1:0];
      if (we_gie) gie_q <= wdata[GIE_POS];
    end
  end

  intr_irq_combine #(.N(NUM_EVT)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .status (status_q),
    .ier    (ier_q),
    .gie    (gie_q),
    .irq    (irq_out)
  );

  intr_key_decode #(.W(DATA_W), .KEY(DATA_W'(SRST_KEY))) u_key (
    .clk   (clk),
    .rst   (rst),
    .hit   (we_srst),
    .wdata (wdata),
    .pulse (soft_rst_pulse)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_STAT: rd_mux[NUM_EVT-1:0] = status_q;
      SEL_IER:  rd_mux[NUM_EVT-1:0] = ier_q;
      SEL_GIE:  rd_mux[GIE_POS]     = gie_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_en ? rd_mux : '0;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/intr_regs_chk.sv
module intr_regs_chk
  import intr_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int N      = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [N-1:0]      evt,
  input logic [N-1:0]      status,
  input logic [N-1:0]      ier,
  input logic              gie,
  input logic              irq,
  input logic              srst
);

  logic stat_wr, key_wr;
  assign stat_wr = wr_en && (addr == ADDR_W'(STAT_OFS));
  assign key_wr  = wr_en && (addr == ADDR_W'(SRST_OFS)) && (wdata == DATA_W'(SRST_KEY));

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((status & $past(evt)) == $past(evt))); // R2 R4

  AST_NO_SPONT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> ((status & $past(status)) == $past(status))); // R3

  AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> ((status & $past(wdata[N-1:0] & ~evt)) == '0)); // R3

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq == ($past(gie) && (|($past(status) & $past(ier)))))); // R7

  AST_SRST_KEY: assert property (@(posedge clk) disable iff (rst)
    key_wr |=> srst); // R8

  AST_SRST_ONLY_KEY: assert property (@(posedge clk) disable iff (rst)
    srst |-> $past(key_wr)); // R9

endmodule

bind intr_regs intr_regs_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .N      (NUM_EVT)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .addr   (addr),
  .wdata  (wdata),
  .evt    (evt_pulse),
  .status (status_q),
  .ier    (ier_q),
  .gie    (gie_q),
  .irq    (irq_out),
  .srst   (soft_rst_pulse)
);

// File: tb/intr_regs_bench.sv
module intr_regs_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [7:0]  evt_pulse;
  logic [31:0] rdata;
  logic        irq_out, soft_rst_pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  intr_regs u_intr_regs (
    .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en), .addr (addr),
    .wdata (wdata), .evt_pulse (evt_pulse), .rdata (rdata),
    .irq_out (irq_out), .soft_rst_pulse (soft_rst_pulse)
  );

  // {req[3:0], op[1:0] (0 idle, 1 write, 2 read), addr, wdata, evt, expected}
  localparam int NV = 24;
  localparam logic [85:0] VEC [NV] = '{
    {4'd1,  2'd2, 8'h20, 32'h0,        8'h00, 32'h0},         // R1
    {4'd1,  2'd2, 8'h28, 32'h0,        8'h00, 32'h0},         // R1
    {4'd1,  2'd2, 8'h1C, 32'h0,        8'h00, 32'h0},         // R1
    {4'd2,  2'd0, 8'h00, 32'h0,        8'h05, 32'h0},         // R2
    {4'd2,  2'd2, 8'h20, 32'h0,        8'h00, 32'h05},        // R2
    {4'd2,  2'd0, 8'h00, 32'h0,        8'h80, 32'h0},         // R2
    {4'd2,  2'd2, 8'h20, 32'h0,        8'h00, 32'h85},        // R2
    {4'd3,  2'd1, 8'h20, 32'h01,       8'h00, 32'h0},         // R3
    {4'd3,  2'd2, 8'h20, 32'h0,        8'h00, 32'h84},        // R3
    {4'd4,  2'd1, 8'h20, 32'h04,       8'h04, 32'h0},         // R4
    {4'd4,  2'd2, 8'h20, 32'h0,        8'h00, 32'h84},        // R4
    {4'd5,  2'd1, 8'h28, 32'hFFFFFF0C, 8'h00, 32'h0},         // R5
    {4'd5,  2'd2, 8'h28, 32'h0,        8'h00, 32'h0C},        // R5
    {4'd6,  2'd1, 8'h1C, 32'hFFFFFFFF, 8'h00, 32'h0},         // R6
    {4'd6,  2'd2, 8'h1C, 32'h0,        8'h00, 32'h80000000},  // R6
    {4'd6,  2'd1, 8'h1C, 32'h7FFFFFFF, 8'h00, 32'h0},         // R6
    {4'd6,  2'd2, 8'h1C, 32'h0,        8'h00, 32'h0},         // R6
    {4'd9,  2'd2, 8'h40, 32'h0,        8'h00, 32'h0},         // R9
    {4'd10, 2'd2, 8'h30, 32'h0,        8'h00, 32'h0},         // R10
    {4'd10, 2'd1, 8'h24, 32'hFFFFFFFF, 8'h00, 32'h0},         // R10
    {4'd10, 2'd2, 8'h20, 32'h0,        8'h00, 32'h84},        // R10
    {4'd10, 2'd2, 8'h28, 32'h0,        8'h00, 32'h0C},        // R10
    {4'd3,  2'd1, 8'h20, 32'hFFFFFFFF, 8'h00, 32'h0},         // R3
    {4'd3,  2'd2, 8'h20, 32'h0,        8'h00, 32'h0}          // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; evt_pulse = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    idle_inputs();
    v = rdata;
  endtask

  task automatic pulse(input logic [7:0] e);
    evt_pulse = e;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1;
    idle_inputs();
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'b0, irq_out}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
    chk("R1 srst", {31'b0, soft_rst_pulse}, 32'h0);
    chk("R1 rdata", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [85:0] e;
      e = VEC[i];
      wr_en     = (e[81:80] == 2'd1);
      rd_en     = (e[81:80] == 2'd2);
      addr      = e[79:72];
      wdata     = e[71:40];
      evt_pulse = e[39:32];
      @(negedge clk);
      idle_inputs();
      if (e[81:80] == 2'd2)
        chk($sformatf("R%0d table step %0d", e[85:82], i), rdata, e[31:0]);
    end

    // R10: read data returns to zero after a cycle without a read
    rd(8'h28, v);
    chk("R10 read IER", v, 32'h0C);
    @(negedge clk);
    chk("R10 idle rdata", rdata, 32'h0);

    // R7: irq timing and gating
    wr(8'h28, 32'h01);
    wr(8'h1C, 32'h80000000);
    pulse(8'h02);
    @(negedge clk);
    chk("R7 masked event", {31'b0, irq_out}, 32'h0);
    evt_pulse = 8'h01;
    @(negedge clk);
    idle_inputs();
    chk("R7 irq one cycle after status", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R7 irq raised", {31'b0, irq_out}, 32'h1);
    wr(8'h1C, 32'h0);
    chk("R7 irq lags gie", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    chk("R7 gie off", {31'b0, irq_out}, 32'h0);
    wr(8'h1C, 32'h80000000);
    @(negedge clk);
    chk("R7 gie on again", {31'b0, irq_out}, 32'h1);
    wr(8'h20, 32'h01);
    @(negedge clk);
    chk("R7 cleared source", {31'b0, irq_out}, 32'h0);
    rd(8'h20, v);
    chk("R3 masked bit kept", v, 32'h02);

    // R8 / R9: soft reset key
    wr(8'h40, 32'h0000000A);
    chk("R8 pulse high", {31'b0, soft_rst_pulse}, 32'h1);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'b0, soft_rst_pulse}, 32'h0);
    wr(8'h40, 32'h0000000B);
    chk("R9 wrong key", {31'b0, soft_rst_pulse}, 32'h0);
    wr(8'h40, 32'h1000000A);
    chk("R9 upper bits set", {31'b0, soft_rst_pulse}, 32'h0);
    wr(8'h20, 32'h0000000A);
    chk("R9 key at other offset", {31'b0, soft_rst_pulse}, 32'h0);

    // R1: reset in the middle of activity
    pulse(8'hFF);
    wr(8'h28, 32'hFF);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", {31'b0, irq_out}, 32'h0);
    rd(8'h20, v);
    chk("R1 status after reset", v, 32'h0);
    rd(8'h28, v);
    chk("R1 enable after reset", v, 32'h0);
    rd(8'h1C, v);
    chk("R1 global enable after reset", v, 32'h0);

    finish_run();
  end

endmodule